// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block is a 48-line, input-only digital port that sits on a simple synchronous byte-wide bus with eight addresses. The lines form six groups of eight. Software reads any group as one byte. It can also ask for an interrupt whenever any line in a chosen group changes level. Every input passes through a two-flop synchronizer. A line toggles when its synchronized value differs from its value one clock earlier, and both rising and falling transitions count.

Interrupts are enabled per group of eight lines, not per line. Each enabled group that sees a transition latches a change flag. The interrupt output is a level that stays high while any flag is set. A status byte shows the latched flags and an active-low pending bit. Reading the status byte clears all flags, and software brings the port up by writing zero to the control address and then reading it.

Top module: `cos_input_port`

## Requirements
- R1: After reset the interrupt output is low and a status read (offset 7) returns 0x40: no group flags and the pending bit (bit 6) high, meaning no interrupt.
- R2: Reads at offsets 0, 1, 2, 4, 5, 6 return groups 0 to 5 in that order, with line 8*k+n of group k on bit n, as seen through a two-flop synchronizer.
- R3: A read at offset 3 returns 0x00.
- R4: A write to offset 7 loads the enable byte, where bit k (k = 0 to 5) enables group k. Writes to any other offset have no effect.
- R5: A rising or a falling transition on any line of an enabled group k sets status bit k, raises the interrupt output and drives status bit 6 to 0.
- R6: Transitions in a disabled group set no flag and raise no interrupt.
- R7: A read strobe at offset 7 returns the current status and then clears all flags. A transition latched in the same cycle as that read survives into the next status.
- R8: Clearing enable bit k clears group k's latched flag on the same clock edge as the write.
- R9: Status bit 7 always reads 0.
- R10: The interrupt output is a level equal to the OR of the latched flags. It stays high until the flags are cleared by a status read or by disabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Byte offset within the window |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read (side effect only at offset 7) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| lineIn | input | 48 | Asynchronous digital inputs |
| irqOut | output | 1 | Active-high interrupt level |

## Verification
The bench targets the hole in the address map. It checks that offset 3 reads zero and that groups 3 to 5 are not shifted by one, which would happen in a design that indexed groups straight from the offset. It sends falling edges as well as rising ones, which catches a detector that only looks for one direction. It also lands a transition on exactly the clock edge of a status read; a design that cleared flags without merging new edges would lose that event. Finally, it disables a group while its flag is set and writes to offsets other than 7. A design that kept stale flags would hold the interrupt high, and a loose address decoder would let such writes change the enable byte.

// File: rtl/cosport_pkg.sv
package cosport_pkg;
  localparam int NUM_GROUPS = 6;
  localparam int GROUP_W    = 8;
  localparam int NUM_LINES  = NUM_GROUPS * GROUP_W;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 8;
  localparam int IDX_W      = $clog2(NUM_GROUPS);

  localparam logic [ADDR_W-1:0] OFS_GAP  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd7;

  typedef struct packed {
    logic             selGroup;
    logic [IDX_W-1:0] groupIdx;
    logic             selStatus;
    logic             wrEnable;
    logic             clrFlags;
  } cosStrobe_t;

  // group offsets skip the gap address
  function automatic logic [IDX_W-1:0] ofsToGroup(input logic [ADDR_W-1:0] ofs);
    logic [ADDR_W-1:0] idx;
    idx = (ofs > OFS_GAP) ? ofs - 3'd1 : ofs;
    return idx[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/cos_datapath.sv
module cos_datapath
  import cosport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  lineIn,
  input  cosStrobe_t            strobe,
  input  logic [DATA_W-1:0]     statusByte,
  output logic [NUM_GROUPS-1:0] groupEdge,
  output logic [DATA_W-1:0]     rdData
);
  logic [NUM_LINES-1:0] syncStage [SYNC_STAGES];
  logic [NUM_LINES-1:0] syncLines;
  logic [NUM_LINES-1:0] prevLines;
  logic [NUM_LINES-1:0] lineEdge;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= lineIn;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncLines = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevLines <= '0;
    else prevLines <= syncLines;
  end

  // both edges: any difference from last clock
  assign lineEdge = syncLines ^ prevLines;

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_edge
      assign groupEdge[g] = |lineEdge[g*GROUP_W +: GROUP_W];
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (strobe.selGroup)
      rdData = syncLines[int'(strobe.groupIdx)*GROUP_W +: GROUP_W];
    else if (strobe.selStatus)
      rdData = statusByte;
  end

  // R2: control must never select a group beyond the last one
  p_group_idx_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selGroup |-> (int'(strobe.groupIdx) < NUM_GROUPS));

  // R9: the status byte handed in keeps bit 7 low
  p_status_top_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selStatus |-> (rdData[7] == 1'b0));
endmodule

// File: rtl/cos_control.sv
module cos_control
  import cosport_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [DATA_W-1:0]     busWrData,
  input  logic [NUM_GROUPS-1:0] groupEdge,
  output cosStrobe_t            strobe,
  output logic [DATA_W-1:0]     statusByte,
  output logic                  irqOut
);
  logic [NUM_GROUPS-1:0] enReg;
  logic [NUM_GROUPS-1:0] enNext;
  logic [NUM_GROUPS-1:0] flags;
  logic [NUM_GROUPS-1:0] flagsNext;
  logic [NUM_GROUPS-1:0] liveEdge;

  always_comb begin
    strobe = '0;
    if (busAddr == OFS_CTRL) begin
      strobe.selStatus = 1'b1;
      strobe.wrEnable  = busWrEn;
      strobe.clrFlags  = busRdEn;
    end else if (busAddr != OFS_GAP) begin
      strobe.selGroup = 1'b1;
      strobe.groupIdx = ofsToGroup(busAddr);
    end
  end

  assign liveEdge  = groupEdge & enReg;
  assign enNext    = strobe.wrEnable ? busWrData[NUM_GROUPS-1:0] : enReg;
  // new edges merge into the cleared set; disabled groups drop at once
  assign flagsNext = ((strobe.clrFlags ? '0 : flags) | liveEdge) & enNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0;
      flags <= '0;
    end else begin
      enReg <= enNext;
      flags <= flagsNext;
    end
  end

  assign irqOut     = |flags;
  assign statusByte = {1'b0, ~irqOut, flags};

  p_wr_loads_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEnable |=> (enReg == $past(busWrData[NUM_GROUPS-1:0])));

  p_edge_latches_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((|liveEdge) && !strobe.wrEnable) |=> ((flags & $past(liveEdge)) == $past(liveEdge)));

  p_disabled_no_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & ~enReg) == '0));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrFlags |=> (flags == ($past(liveEdge) & enReg)));

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEnable |=> ((flags & ~$past(busWrData[NUM_GROUPS-1:0])) == '0));

  p_irq_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !strobe.clrFlags && !strobe.wrEnable) |=> irqOut);
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
  import cosport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic [47:0] lineIn,
  output logic        irqOut
);
  cosStrobe_t            strobe;
  logic [DATA_W-1:0]     statusByte;
  logic [NUM_GROUPS-1:0] groupEdge;

  cos_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busWrData  (busWrData),
    .groupEdge  (groupEdge),
    .strobe     (strobe),
    .statusByte (statusByte),
    .irqOut     (irqOut)
  );

  cos_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineIn),
    .strobe     (strobe),
    .statusByte (statusByte),
    .groupEdge  (groupEdge),
    .rdData     (busRdData)
  );
endmodule

// File: tb/test_cos_input_port.sv
`timescale 1ns/1ps
module test_cos_input_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [47:0] lines = '0;
  logic        irqOut;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  cos_input_port i_cos_input_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .lineIn(lines), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    tick();
    busRdEn = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    peek(3'd7, d);
    check("R1 status after reset", d, 8'h40);
    check("R1 irq after reset", {7'd0, irqOut}, 8'h00);
    busWrite(3'd7, 8'h00);
    busRead(3'd7, d);
    check("R9 status bit7", {7'd0, d[7]}, 8'h00);
  endtask

  task automatic t_groups;
    logic [7:0] d;
    logic [2:0] ofs [6] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6};
    lines = 48'hA5_3C_96_0F_E1_11;
    tick(3);
    for (int g = 0; g < 6; g++) begin
      peek(ofs[g], d);
      check($sformatf("R2 group %0d", g), d, lines[g*8 +: 8]);
    end
    peek(3'd3, d);
    check("R3 gap offset", d, 8'h00);
  endtask

  task automatic t_edges;
    logic [7:0] d;
    busWrite(3'd7, 8'h01);
    lines[1] = 1'b1;               // rising in group 0
    tick(4);
    check("R5 irq on rise", {7'd0, irqOut}, 8'h01);
    tick(5);
    check("R10 irq level held", {7'd0, irqOut}, 8'h01);
    busRead(3'd7, d);
    check("R5 status on rise", d, 8'h01);
    check("R7 irq cleared by read", {7'd0, irqOut}, 8'h00);
    peek(3'd7, d);
    check("R7 status after read", d, 8'h40);
    lines[4] = 1'b0;               // falling in group 0
    tick(4);
    peek(3'd7, d);
    check("R5 status on fall", d, 8'h01);
    busRead(3'd7, d);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    lines[17] = ~lines[17];        // group 2, disabled
    tick(5);
    check("R6 irq disabled group", {7'd0, irqOut}, 8'h00);
    peek(3'd7, d);
    check("R6 status disabled group", d, 8'h40);
  endtask

  task automatic t_ignored_write;
    logic [7:0] d;
    busWrite(3'd3, 8'hFF);
    busWrite(3'd0, 8'hFF);
    busWrite(3'd6, 8'hFF);
    lines[33] = ~lines[33];        // group 4
    tick(5);
    check("R4 stray write no enable", {7'd0, irqOut}, 8'h00);
    peek(3'd0, d);
    check("R4 stray write no data", d, lines[7:0]);
  endtask

  task automatic t_disable_clears;
    logic [7:0] d;
    busWrite(3'd7, 8'h3F);
    lines[47] = ~lines[47];        // group 5
    tick(4);
    peek(3'd7, d);
    check("R5 group 5 flag", d, 8'h20);
    busWrite(3'd7, 8'h1F);
    check("R8 irq after disable", {7'd0, irqOut}, 8'h00);
    peek(3'd7, d);
    check("R8 status after disable", d, 8'h40);
  endtask

  task automatic t_coincide;
    logic [7:0] d;
    busWrite(3'd7, 8'h03);
    lines[2] = ~lines[2];          // group 0
    tick(4);
    lines[9] = ~lines[9];          // group 1, latches on the read edge
    tick(2);
    busRead(3'd7, d);
    check("R7 read value before merge", d, 8'h01);
    peek(3'd7, d);
    check("R7 coincident edge kept", d, 8'h02);
    check("R10 irq still set", {7'd0, irqOut}, 8'h01);
    busRead(3'd7, d);
  endtask

  task automatic t_all_groups;
    logic [7:0] d;
    busWrite(3'd7, 8'h3F);
    lines = ~lines;
    tick(4);
    peek(3'd7, d);
    check("R5 all group flags", d, 8'h3F);
    check("R9 bit7 with all flags", {7'd0, d[7]}, 8'h00);
    busRead(3'd7, d);
    busWrite(3'd7, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();
    t_reset();
    t_groups();
    t_edges();
    t_disabled();
    t_ignored_write();
    t_disable_clears();
    t_coincide();
    t_all_groups();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule